// File: doc/BRIEF.md
# Binary-weighted grayscale duty modulator

This block turns an n-bit brightness code per pixel into a lit/dark pattern spread over one refresh period. A single timer, shared by every pixel, walks through n segments, one per code bit. Segment i lasts 2^i base ticks, so its length is proportional to the weight of bit i. During segment i each pixel is lit exactly when bit i of its code is set. Over one period a pixel is therefore lit for a time proportional to its code, and all pixels change segment in the same cycle.

A period starts when the refresh strobe arrives while the timer is idle. The codes are captured at that moment and held for the whole period, so a code change on the input can never tear a period. A base tick is `TICK_CYCLES` clock cycles long. The period is made of 2^n − 1 ticks of segments followed by one dark blanking tick. The strobe spacing therefore sets the refresh rate, for example 70 periods per second.

The controller has three states. `ST_IDLE` waits dark for the strobe. `ST_RUN` drives the segments. `ST_BLANK` is the dark tick that closes a period. Four transitions connect them: *start* (ST_IDLE→ST_RUN on an accepted strobe), *advance* (ST_RUN→ST_RUN when a segment ends and more bits remain), *finish* (ST_RUN→ST_BLANK after the MSB segment) and *release* (ST_BLANK→ST_IDLE when the blanking tick ends).

Top module: `gsm_duty_mod`

## Requirements
- R1: While reset (rst_n low, asynchronous) is applied, and in the first cycle after it, `seg_idx` is 0, `seg_start` is 0 and every bit of `pix_on` is 0.
- R2: A `refresh` high at a clock edge while the timer is idle starts a period. From the next cycle on, `seg_idx` is 0 and `seg_start` is 1.
- R3: Segments run in ascending order from 0 to BITS−1. Segment i holds `seg_idx` = i for exactly TICK_CYCLES·2^i cycles.
- R4: `seg_start` is high for exactly one cycle, the first cycle of each segment, and is low in every other cycle.
- R5: During segment i, `pix_on[p]` equals bit i of the code captured for pixel p. Pixel p's code occupies `codes[p*BITS +: BITS]`, with bit 0 as the LSB.
- R6: Codes are captured only at the edge that starts a period. Changes on `codes` during a period have no effect on `pix_on` in that period.
- R7: A `refresh` high while a period is running or blanking is ignored. The segment sequence continues undisturbed.
- R8: After the MSB segment, `pix_on` is 0 and `seg_idx` is 0 for TICK_CYCLES cycles. The timer then idles dark without any `seg_start` until the next strobe.
- R9: Over one period, pixel p is lit for exactly code_p · TICK_CYCLES cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| refresh | input | 1 | Period start strobe, honoured only when idle |
| codes | input | PIXELS*BITS | Packed brightness codes, pixel p at [p*BITS +: BITS] |
| seg_idx | output | $clog2(BITS) | Index of the current segment |
| seg_start | output | 1 | One-cycle pulse at the first cycle of each segment |
| pix_on | output | PIXELS | Per-pixel lit enable |

## Verification
The main function is first tried with directed code sets. These include all-zero and all-one codes, which separate a never-lit pixel from an always-lit one. Single-bit codes at the LSB and MSB expose a wrong segment order or length. Alternating patterns expose a swapped bit select. Random codes follow, with random code changes and stray strobes during every period. Any tearing or restart then shows as a segment, pulse or lit-time mismatch. A reset in the middle of a period checks the return to a dark idle state.

// File: rtl/gsm_pkg.sv
package gsm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_BLANK = 2'd2
    } gsm_state_e;
endpackage

// File: rtl/gsm_seg_timer.sv
module gsm_seg_timer
    import gsm_pkg::*;
#(
    parameter int BITS        = 8,
    parameter int TICK_CYCLES = 2,
    localparam int SEGW       = (BITS > 1) ? $clog2(BITS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            refresh,
    output logic            load,
    output logic            run,
    output logic [SEGW-1:0] seg_idx,
    output logic            seg_start
);
    localparam int CNTW = BITS + $clog2(TICK_CYCLES + 1) + 1;
    localparam logic [SEGW-1:0] LAST_SEG  = SEGW'(BITS - 1);
    localparam logic [CNTW-1:0] BLANK_END = CNTW'(TICK_CYCLES - 1);

    gsm_state_e      state, state_n;
    logic [SEGW-1:0] seg, seg_n;
    logic [CNTW-1:0] cnt, cnt_n;
    logic            start_q, start_n;
    logic [CNTW-1:0] seg_end;

    assign seg_end = (CNTW'(TICK_CYCLES) << seg) - CNTW'(1);

    // next-state logic
    always_comb begin
        state_n = state;
        seg_n   = seg;
        cnt_n   = cnt;
        start_n = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (refresh) begin          // start
                    state_n = ST_RUN;
                    seg_n   = '0;
                    cnt_n   = '0;
                    start_n = 1'b1;
                end
            end
            ST_RUN: begin
                if (cnt == seg_end) begin
                    cnt_n = '0;
                    if (seg == LAST_SEG) begin  // finish
                        state_n = ST_BLANK;
                        seg_n   = '0;
                    end else begin              // advance
                        seg_n   = seg + SEGW'(1);
                        start_n = 1'b1;
                    end
                end else begin
                    cnt_n = cnt + CNTW'(1);
                end
            end
            ST_BLANK: begin
                if (cnt == BLANK_END) begin     // release
                    state_n = ST_IDLE;
                    cnt_n   = '0;
                end else begin
                    cnt_n = cnt + CNTW'(1);
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            seg     <= '0;
            cnt     <= '0;
            start_q <= 1'b0;
        end else begin
            state   <= state_n;
            seg     <= seg_n;
            cnt     <= cnt_n;
            start_q <= start_n;
        end
    end

    // outputs
    always_comb begin
        load      = (state == ST_IDLE) && refresh;
        run       = (state == ST_RUN);
        seg_idx   = seg;
        seg_start = start_q;
    end

    p_seg_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        seg_idx <= LAST_SEG);
    p_seg_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && seg_start && $past(run)) |-> (seg_idx == $past(seg_idx) + SEGW'(1)));
    p_seg_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !seg_start) |-> $stable(seg_idx));
    p_start_in_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
        seg_start |-> run);
    p_no_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && refresh && !(cnt == seg_end && seg == LAST_SEG)) |=> run);
    p_blank_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BLANK) |-> (cnt <= BLANK_END && seg_idx == '0));
endmodule

// File: rtl/gsm_pix_sel.sv
module gsm_pix_sel #(
    parameter int BITS = 8,
    parameter int SEGW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            run,
    input  logic [SEGW-1:0] seg_idx,
    input  logic [BITS-1:0] code_in,
    output logic            pix_on
);
    logic [BITS-1:0] code_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    code_q <= '0;
        else if (load) code_q <= code_in;
    end

    assign pix_on = run & code_q[seg_idx];
endmodule

// File: rtl/gsm_duty_mod.sv
module gsm_duty_mod #(
    parameter int BITS        = 8,
    parameter int PIXELS      = 4,
    parameter int TICK_CYCLES = 2,
    localparam int SEGW       = (BITS > 1) ? $clog2(BITS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   refresh,
    input  logic [PIXELS*BITS-1:0] codes,
    output logic [SEGW-1:0]        seg_idx,
    output logic                   seg_start,
    output logic [PIXELS-1:0]      pix_on
);
    logic load, run;

    gsm_seg_timer #(.BITS(BITS), .TICK_CYCLES(TICK_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .refresh(refresh),
        .load(load), .run(run), .seg_idx(seg_idx), .seg_start(seg_start)
    );

    for (genvar p = 0; p < PIXELS; p++) begin : g_pix
        gsm_pix_sel #(.BITS(BITS), .SEGW(SEGW)) u_sel (
            .clk(clk), .rst_n(rst_n), .load(load), .run(run),
            .seg_idx(seg_idx), .code_in(codes[p*BITS +: BITS]),
            .pix_on(pix_on[p])
        );
    end

    p_dark_off_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (pix_on == '0));
    p_pix_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !seg_start) |-> $stable(pix_on));
    p_reset_dark_r1: assert property (@(posedge clk)
        !rst_n |-> (pix_on == '0 && !seg_start));
endmodule

// File: tb/gsm_duty_mod_test.sv
`timescale 1ns/1ps
module gsm_duty_mod_test;
    localparam int BITS = 8;
    localparam int PIX  = 4;
    localparam int TICK = 2;
    localparam int SEGW = $clog2(BITS);
    localparam int W    = PIX * BITS;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            refresh;
    logic [W-1:0]    codes;
    logic [SEGW-1:0] seg_idx;
    logic            seg_start;
    logic [PIX-1:0]  pix_on;

    int errs   = 0;
    int checks = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    gsm_duty_mod #(.BITS(BITS), .PIXELS(PIX), .TICK_CYCLES(TICK)) uut (
        .clk(clk), .rst_n(rst_n), .refresh(refresh), .codes(codes),
        .seg_idx(seg_idx), .seg_start(seg_start), .pix_on(pix_on)
    );

    function automatic int seg_len(input int i);
        return TICK << i;
    endfunction

    function automatic logic [PIX-1:0] exp_pix(input logic [W-1:0] c, input int i);
        logic [PIX-1:0] r;
        for (int p = 0; p < PIX; p++) r[p] = c[p*BITS + i];
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_dark(input string req);
        chk(seg_idx == 0, req, int'(seg_idx), 0);
        chk(seg_start == 1'b0, req, int'(seg_start), 0);
        chk(pix_on == '0, req, int'(pix_on), 0);
    endtask

    task automatic run_period(input logic [W-1:0] c, input bit disturb);
        int on_cnt [PIX];
        for (int p = 0; p < PIX; p++) on_cnt[p] = 0;
        codes   = c;
        refresh = 1'b1;
        @(negedge clk);
        refresh = 1'b0;
        for (int i = 0; i < BITS; i++) begin
            for (int k = 0; k < seg_len(i); k++) begin
                if (i == 0 && k == 0) chk(seg_start == 1'b1, "R2", int'(seg_start), 1);
                chk(int'(seg_idx) == i, "R3", int'(seg_idx), i);
                chk(seg_start == (k == 0), "R4", int'(seg_start), int'(k == 0));
                chk(pix_on == exp_pix(c, i), disturb ? "R6" : "R5",
                    int'(pix_on), int'(exp_pix(c, i)));
                for (int p = 0; p < PIX; p++) on_cnt[p] += int'(pix_on[p]);
                if (disturb) begin
                    codes   = W'($urandom);
                    refresh = 1'($urandom % 2);   // R7: stray strobes
                end
                @(negedge clk);
            end
        end
        for (int k = 0; k < TICK; k++) begin
            chk_dark("R8");
            if (disturb) begin
                codes   = W'($urandom);
                refresh = 1'($urandom % 2);
            end
            @(negedge clk);
        end
        refresh = 1'b0;
        chk_dark("R8");   // idle, no restart from stray strobe (R7)
        for (int p = 0; p < PIX; p++)
            chk(on_cnt[p] == int'(c[p*BITS +: BITS]) * TICK, "R9",
                on_cnt[p], int'(c[p*BITS +: BITS]) * TICK);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n   = 1'b0;
        refresh = 1'b0;
        codes   = '0;
        repeat (3) @(negedge clk);
        chk_dark("R1");
        rst_n = 1'b1;
        @(negedge clk);
        chk_dark("R1");
        repeat (3) @(negedge clk);
        chk_dark("R8");

        run_period({8'h00, 8'hFF, 8'h80, 8'h01}, 1'b0);
        run_period({8'hAA, 8'h55, 8'h0F, 8'hF0}, 1'b0);
        for (int n = 0; n < 8; n++) run_period(W'($urandom), 1'b1);
        repeat (5) @(negedge clk);
        chk_dark("R8");

        codes   = {8'hFF, 8'hFF, 8'hFF, 8'hFF};
        refresh = 1'b1;
        @(negedge clk);
        refresh = 1'b0;
        repeat (20) @(negedge clk);
        chk(pix_on == '1, "R5", int'(pix_on), 15);
        rst_n = 1'b0;
        @(negedge clk);
        chk_dark("R1");
        rst_n = 1'b1;
        @(negedge clk);
        chk_dark("R1");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule